// File: doc/BRIEF.md
# Two-way write-back data cache

This block is a set-associative data cache with two ways per set, placed between a processor load/store port and a memory port that moves whole lines. Loads and stores of 1, 2, 4, 8 or 16 bytes are served from the line arrays. A store always allocates: it fills the line first and then merges its bytes into the line. Modified lines go back to memory only when they are evicted.

A request is held on the processor side until `cpu_done` is seen high at a clock edge. A hit completes in the cycle it is presented. On a miss the block raises `cpu_busy`, chooses a victim way, and writes the victim's line out if it is valid and dirty. It then reads the new line in a single wide transfer and completes the access in the cycle after the fill is acknowledged. Each set keeps one replacement bit per way. The victim is the exclusive-or of the two bits, and each fill inverts the bit of the way it filled. From reset, successive misses to one set therefore alternate between the ways.

Top module: `dcache2w_wb`

## Requirements
- R1: After reset every line is invalid and all tag state is clear. `cpu_busy`, `cpu_done` and `mem_req` are low. The first miss into any set issues only a line read (`mem_we`=0) and no writeback.
- R2: An access whose line is valid with a matching tag is a hit. A hit raises `cpu_done` combinationally in the cycle it is presented, with no memory request.
- R3: With the default parameters the set index is address bits 11:6, the line offset is bits 5:0 and the tag is bits 31:12. Accesses to a different set never disturb another set's lines.
- R4: On a miss the victim way equals the replacement bit of way 0 XOR that of way 1, and the fill inverts the filled way's bit. A line that was not chosen stays resident and still hits.
- R5: A victim that is valid and dirty is written back before the refill. The write is one transfer with `mem_we`=1, at address {victim tag, set index, 6'b0}, carrying the full current line contents.
- R6: A victim that is clean or invalid is not written back; only the line read is issued.
- R7: The refill reads address {access address bits 31:6, 6'b0}. It installs the returned 64 bytes and leaves the line valid and clean.
- R8: Every store sets the line's dirty bit, both on a hit and after allocation. Its low N bytes land at the line offset aligned down to N. Byte k of the line is address offset k, little-endian in the 512-bit line. No other byte changes.
- R9: A load returns N bytes from the line offset aligned down to N in `cpu_rdata` bits 8N-1:0, with the upper bits zero. `cpu_size` codes 0, 1, 2, 3 and 4 select N = 1, 2, 4, 8 and 16; codes above 4 act as 4.
- R10: `cpu_busy` is high throughout a writeback or refill. `cpu_done` is high in the cycle following the clock edge at which the fill acknowledge was sampled.
- R11: Once `mem_req` is raised, it stays high with `mem_addr` and `mem_we` unchanged until `mem_ack` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Access request, held until done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 3 | Access size code, N = 2^code bytes |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | CPU_BYTES*8 | Store data, low N bytes used |
| cpu_rdata | output | CPU_BYTES*8 | Load data, zero-extended |
| cpu_done | output | 1 | Access completes at this clock edge |
| cpu_busy | output | 1 | Writeback or refill in progress |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | LINE_BYTES*8 | Line written back |
| mem_rdata | input | LINE_BYTES*8 | Line returned by a read |
| mem_ack | input | 1 | Transfer complete |

## Verification
The bench drives three different tags through one set. The third miss must evict the dirty first line and write it out at its own tag, not at the tag of the access. A design with the replacement XOR wrong would evict the line that was just filled, so the following access to the surviving line would go to memory. A store that is unaligned for its size must land on the aligned boundary and must write only N bytes, with the upper store data driven to ones. A store that allocates on a miss must later produce a writeback when it is evicted; a cache that marked only hit stores dirty would silently drop that data. A refill after writeback must return the modified bytes. The bench also checks the timing of done against the fill acknowledge and the stability of the memory request while it waits. Both catch an FSM that releases the request early or completes one cycle late.

// File: rtl/dcache_pkg.sv
package dcache_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WBACK = 2'd1,
      ST_FILL  = 2'd2
   } dc_state_e;

endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
   parameter int SETS  = 64,
   parameter int IDX_W = 6,
   parameter int TAG_W = 20
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [IDX_W-1:0]      idx,
   input  logic [TAG_W-1:0]      tag_in,
   output logic [1:0]            hit,
   output logic [1:0]            valid,
   output logic [1:0]            dirty,
   output logic [1:0]            repl,
   output logic [1:0][TAG_W-1:0] tag_rd,
   input  logic                  fill_en,
   input  logic                  fill_way,
   input  logic                  mark_en,
   input  logic                  mark_way
);

   logic [TAG_W-1:0] tag_q [SETS][2];
   logic [1:0]       vld_q [SETS];
   logic [1:0]       drt_q [SETS];
   logic [1:0]       rpl_q [SETS];

   for (genvar w = 0; w < 2; w++) begin : g_way
      assign tag_rd[w] = tag_q[idx][w];
      assign valid[w]  = vld_q[idx][w];
      assign dirty[w]  = drt_q[idx][w];
      assign repl[w]   = rpl_q[idx][w];
      assign hit[w]    = vld_q[idx][w] && (tag_q[idx][w] == tag_in);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            tag_q[s][0] <= '0;
            tag_q[s][1] <= '0;
            vld_q[s]    <= '0;
            drt_q[s]    <= '0;
            rpl_q[s]    <= '0;
         end
      end else begin
         if (fill_en) begin
            tag_q[idx][fill_way] <= tag_in;
            vld_q[idx][fill_way] <= 1'b1;
            drt_q[idx][fill_way] <= 1'b0;
            rpl_q[idx][fill_way] <= ~rpl_q[idx][fill_way];
         end else if (mark_en) begin
            drt_q[idx][mark_way] <= 1'b1;
         end
      end
   end

   // R7: a refilled line becomes valid and clean
   p_refill_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (vld_q[$past(idx)][$past(fill_way)] && !drt_q[$past(idx)][$past(fill_way)]));

   // R4: the filled way's replacement bit flips
   p_repl_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (rpl_q[$past(idx)][$past(fill_way)] != $past(rpl_q[idx][fill_way])));

   // R8: a store leaves its line dirty
   p_store_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mark_en && !fill_en) |=> drt_q[$past(idx)][$past(mark_way)]);

endmodule

// File: rtl/dc_line_store.sv
module dc_line_store #(
   parameter int SETS       = 64,
   parameter int IDX_W      = 6,
   parameter int LINE_BYTES = 64,
   parameter int OFF_W      = 6,
   parameter int CPU_BYTES  = 16
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [IDX_W-1:0]             idx,
   output logic [1:0][LINE_BYTES*8-1:0] line_rd,
   input  logic                         fill_en,
   input  logic                         fill_way,
   input  logic [LINE_BYTES*8-1:0]      fill_data,
   input  logic                         wr_en,
   input  logic                         acc_way,
   input  logic [OFF_W-1:0]             acc_off,
   input  logic [2:0]                   acc_log,
   input  logic [CPU_BYTES*8-1:0]       wr_data,
   output logic [CPU_BYTES*8-1:0]       rd_data
);

   localparam int LINE_BITS = LINE_BYTES * 8;
   localparam int CPU_BITS  = CPU_BYTES * 8;

   logic [LINE_BITS-1:0]  data_q [2*SETS];
   logic [LINE_BYTES-1:0] nmask;
   logic [LINE_BYTES-1:0] bmask;
   logic [LINE_BITS-1:0]  wide;
   logic [LINE_BITS-1:0]  cur;
   logic [LINE_BITS-1:0]  merged;
   logic [LINE_BITS-1:0]  rsh;

   for (genvar w = 0; w < 2; w++) begin : g_rd
      assign line_rd[w] = data_q[{idx, 1'(w)}];
   end

   always_comb begin
      nmask = (LINE_BYTES'(1) << (LINE_BYTES'(1) << acc_log)) - LINE_BYTES'(1);
      bmask = nmask << acc_off;
      wide  = LINE_BITS'(wr_data) << {acc_off, 3'b000};
      cur   = line_rd[acc_way];
      rsh   = cur >> {acc_off, 3'b000};
   end

   for (genvar b = 0; b < LINE_BYTES; b++) begin : g_merge
      assign merged[b*8 +: 8] = bmask[b] ? wide[b*8 +: 8] : cur[b*8 +: 8];
   end

   for (genvar j = 0; j < CPU_BYTES; j++) begin : g_extract
      assign rd_data[j*8 +: 8] = nmask[j] ? rsh[j*8 +: 8] : 8'h00;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 2*SETS; i++) data_q[i] <= '0;
      end else if (fill_en) begin
         data_q[{idx, fill_way}] <= fill_data;
      end else if (wr_en) begin
         data_q[{idx, acc_way}] <= merged;
      end
   end

   // R7: the refilled line holds exactly what memory returned
   p_fill_lands_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fill_en |=> (data_q[{$past(idx), $past(fill_way)}] == $past(fill_data)));

   // R9: nothing beyond CPU_BITS is implied by the size code
   p_size_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ((32'd1 << acc_log) <= CPU_BYTES));

endmodule

// File: rtl/dc_ctrl.sv
module dc_ctrl
   import dcache_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      cpu_req,
   input  logic      hit_any,
   input  logic      victim_in,
   input  logic      victim_dv,
   input  logic      mem_ack,
   output dc_state_e state,
   output logic      vict_q,
   output logic      busy,
   output logic      done,
   output logic      mem_req,
   output logic      mem_we,
   output logic      fill_en
);

   dc_state_e state_q, state_d;

   assign state   = state_q;
   assign busy    = (state_q != ST_IDLE);
   assign done    = (state_q == ST_IDLE) && cpu_req && hit_any;
   assign mem_req = (state_q == ST_WBACK) || (state_q == ST_FILL);
   assign mem_we  = (state_q == ST_WBACK);
   assign fill_en = (state_q == ST_FILL) && mem_ack;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (cpu_req && !hit_any) state_d = victim_dv ? ST_WBACK : ST_FILL;
         ST_WBACK: if (mem_ack) state_d = ST_FILL;
         ST_FILL:  if (mem_ack) state_d = ST_IDLE;
         default:  state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         vict_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_IDLE && cpu_req && !hit_any) vict_q <= victim_in;
      end
   end

   // R10: with the request still held, the access completes right after the fill
   p_done_after_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_FILL && mem_ack && cpu_req) |=> done);

   // R11: an outstanding transfer keeps its request and direction
   p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we)));

   // R5: a writeback is always followed by the refill read
   p_wb_then_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WBACK && mem_ack) |=> (mem_req && !mem_we));

endmodule

// File: rtl/dcache2w_wb.sv
module dcache2w_wb
   import dcache_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int SETS       = 64,
   parameter int LINE_BYTES = 64,
   parameter int CPU_BYTES  = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cpu_req,
   input  logic                    cpu_we,
   input  logic [2:0]              cpu_size,
   input  logic [ADDR_W-1:0]       cpu_addr,
   input  logic [CPU_BYTES*8-1:0]  cpu_wdata,
   output logic [CPU_BYTES*8-1:0]  cpu_rdata,
   output logic                    cpu_done,
   output logic                    cpu_busy,
   output logic                    mem_req,
   output logic                    mem_we,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [LINE_BYTES*8-1:0] mem_wdata,
   input  logic [LINE_BYTES*8-1:0] mem_rdata,
   input  logic                    mem_ack
);

   localparam int OFF_W     = $clog2(LINE_BYTES);
   localparam int IDX_W     = $clog2(SETS);
   localparam int TAG_W     = ADDR_W - OFF_W - IDX_W;
   localparam int LOG_CPU   = $clog2(CPU_BYTES);
   localparam int LINE_BITS = LINE_BYTES * 8;

   if ((1 << OFF_W) != LINE_BYTES || (1 << IDX_W) != SETS || (1 << LOG_CPU) != CPU_BYTES
       || CPU_BYTES > LINE_BYTES || LOG_CPU > 7 || TAG_W < 1) begin : g_bad_cfg
      $error("dcache2w_wb: unsupported geometry");
   end

   logic [IDX_W-1:0]      idx;
   logic [TAG_W-1:0]      tag;
   logic [OFF_W-1:0]      off;
   logic [OFF_W-1:0]      acc_off;
   logic [2:0]            acc_log;
   logic [1:0]            hit, valid, dirty, repl;
   logic [1:0][TAG_W-1:0] tag_rd;
   logic [1:0][LINE_BITS-1:0] line_rd;
   logic                  hit_any, hit_way, victim_in, victim_dv, vict_q, fill_en, busy, done;
   dc_state_e             state;

   assign idx     = cpu_addr[OFF_W +: IDX_W];
   assign tag     = cpu_addr[ADDR_W-1 -: TAG_W];
   assign off     = cpu_addr[OFF_W-1:0];
   assign acc_log = (cpu_size > 3'(LOG_CPU)) ? 3'(LOG_CPU) : cpu_size;
   assign acc_off = off & ~OFF_W'((32'd1 << acc_log) - 32'd1);

   assign hit_any   = |hit;
   assign hit_way   = ~hit[0];
   assign victim_in = repl[0] ^ repl[1];
   assign victim_dv = valid[victim_in] & dirty[victim_in];

   dc_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_req   (cpu_req),
      .hit_any   (hit_any),
      .victim_in (victim_in),
      .victim_dv (victim_dv),
      .mem_ack   (mem_ack),
      .state     (state),
      .vict_q    (vict_q),
      .busy      (busy),
      .done      (done),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .fill_en   (fill_en)
   );

   dc_tag_store #(.SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .idx      (idx),
      .tag_in   (tag),
      .hit      (hit),
      .valid    (valid),
      .dirty    (dirty),
      .repl     (repl),
      .tag_rd   (tag_rd),
      .fill_en  (fill_en),
      .fill_way (vict_q),
      .mark_en  (done && cpu_we),
      .mark_way (hit_way)
   );

   dc_line_store #(.SETS(SETS), .IDX_W(IDX_W), .LINE_BYTES(LINE_BYTES),
                   .OFF_W(OFF_W), .CPU_BYTES(CPU_BYTES)) u_lines (
      .clk       (clk),
      .rst_n     (rst_n),
      .idx       (idx),
      .line_rd   (line_rd),
      .fill_en   (fill_en),
      .fill_way  (vict_q),
      .fill_data (mem_rdata),
      .wr_en     (done && cpu_we),
      .acc_way   (hit_way),
      .acc_off   (acc_off),
      .acc_log   (acc_log),
      .wr_data   (cpu_wdata),
      .rd_data   (cpu_rdata)
   );

   assign cpu_done  = done;
   assign cpu_busy  = busy;
   assign mem_wdata = line_rd[vict_q];
   assign mem_addr  = (state == ST_WBACK) ? {tag_rd[vict_q], idx, OFF_W'(0)}
                                          : {cpu_addr[ADDR_W-1:OFF_W], OFF_W'(0)};

   // R2: a hit never touches memory
   p_hit_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done |-> !mem_req);

   // R11: the line address holds until acknowledged
   p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> $stable(mem_addr));

   // R6: a miss with a clean or empty victim goes straight to the line read
   p_clean_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!cpu_busy && cpu_req && !hit_any && !victim_dv) |=> (mem_req && !mem_we));

endmodule

// File: tb/dcache2w_wb_bench.sv
`timescale 1ns/1ps
module dcache2w_wb_bench;

   localparam int LAT = 3;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         cpu_req = 1'b0, cpu_we = 1'b0;
   logic [2:0]   cpu_size = '0;
   logic [31:0]  cpu_addr = '0;
   logic [127:0] cpu_wdata = '0;
   logic [127:0] cpu_rdata;
   logic         cpu_done, cpu_busy, mem_req, mem_we;
   logic [31:0]  mem_addr;
   logic [511:0] mem_wdata;
   logic [511:0] mem_rdata = '0;
   logic         mem_ack = 1'b0;

   dcache2w_wb u_dcache2w_wb (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
      .cpu_busy(cpu_busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack));

   always #2.5 clk = ~clk;

   int n_chk = 0, n_bad = 0, cyc = 0;
   int rd_count = 0, wr_count = 0, seq = 0, rd_seq = 0, wr_seq = 0;
   int ack_edge = 0, done_cyc = 0, hold_err = 0, busy_err = 0;
   logic [31:0]  last_rd_addr = '0, last_wr_addr = '0;
   logic [511:0] last_wr_data = '0;
   logic [31:0]  tbl_a [8];
   logic [511:0] tbl_d [8];
   int tbl_n = 0;
   bit finished = 0;

   initial forever begin @(posedge clk); cyc++; end

   function automatic logic [7:0] pat(logic [31:0] a);
      return a[7:0] ^ a[19:12] ^ 8'h3C;
   endfunction

   function automatic logic [127:0] patv(logic [31:0] a, int n);
      logic [127:0] v = '0;
      for (int k = 0; k < n; k++) v[k*8 +: 8] = pat(a + 32'(k));
      return v;
   endfunction

   function automatic logic [511:0] lookup(logic [31:0] a);
      logic [511:0] v = '0;
      for (int i = 0; i < tbl_n; i++) if (tbl_a[i] == a) return tbl_d[i];
      for (int k = 0; k < 64; k++) v[k*8 +: 8] = pat(a + 32'(k));
      return v;
   endfunction

   // memory model: answers after LAT cycles, checks request stability
   initial begin
      int wcnt = 0;
      logic [31:0] cap_a = '0;
      logic cap_we = 1'b0;
      forever begin
         @(negedge clk);
         mem_ack = 1'b0;
         if (mem_req) begin
            wcnt++;
            if (!cpu_busy) busy_err++;
            if (wcnt == 1) begin cap_a = mem_addr; cap_we = mem_we; end
            else if (mem_addr != cap_a || mem_we != cap_we) hold_err++;
            if (wcnt == LAT) begin
               seq++;
               if (mem_we) begin
                  int slot = tbl_n;
                  for (int i = 0; i < tbl_n; i++) if (tbl_a[i] == mem_addr) slot = i;
                  tbl_a[slot] = mem_addr; tbl_d[slot] = mem_wdata;
                  if (slot == tbl_n) tbl_n++;
                  wr_count++; wr_seq = seq; last_wr_addr = mem_addr; last_wr_data = mem_wdata;
               end else begin
                  mem_rdata = lookup(mem_addr);
                  rd_count++; rd_seq = seq; last_rd_addr = mem_addr;
               end
               mem_ack = 1'b1;
               ack_edge = cyc + 1;
               wcnt = 0;
            end
         end else wcnt = 0;
      end
   end

   task automatic chk(input bit ok, input string rq, input logic [511:0] act, input logic [511:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   task automatic acc(input bit we, input logic [2:0] sz, input logic [31:0] a,
                      input logic [127:0] wd, output logic [127:0] rd, output int waited);
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
      #1;
      waited = 0;
      while (!cpu_done && waited < 1000) begin
         @(negedge clk); #1; waited++;
      end
      rd = cpu_rdata;
      done_cyc = cyc;
      @(posedge clk); #1;
      cpu_req = 1'b0; cpu_we = 1'b0;
   endtask

   localparam logic [31:0] A = 32'h0001_00C0;  // set 3
   localparam logic [31:0] B = A + 32'h1000;
   localparam logic [31:0] C = A + 32'h2000;
   localparam logic [31:0] D = 32'h0004_0280;  // set 10
   localparam logic [31:0] E = D + 32'h1000;
   localparam logic [31:0] F = D + 32'h2000;

   task automatic t_reset;
      chk(!cpu_busy && !cpu_done && !mem_req, "R1 idle outputs after reset",
          {cpu_busy, cpu_done, mem_req}, 3'b000);
   endtask

   task automatic t_cold_miss;
      logic [127:0] rd; int w;
      acc(0, 3'd2, A + 32'h14, '0, rd, w);
      chk(rd_count == 1 && wr_count == 0, "R1 first miss is a read only", {rd_count, wr_count}, {32'd1, 32'd0});
      chk(last_rd_addr == A, "R7 fill address line aligned", last_rd_addr, A);
      chk(rd == patv(A + 32'h14, 4), "R9 4-byte load after fill", rd, patv(A + 32'h14, 4));
      chk(done_cyc == ack_edge, "R10 done one cycle after fill ack", done_cyc, ack_edge);
   endtask

   task automatic t_hit_reads;
      logic [127:0] rd; int w; int r0 = rd_count;
      acc(0, 3'd3, A + 32'h2B, '0, rd, w);
      chk(w == 0 && rd_count == r0, "R2 hit completes at once", w, 0);
      chk(rd == patv(A + 32'h28, 8), "R9 8-byte load aligned down", rd, patv(A + 32'h28, 8));
      acc(0, 3'd0, A + 32'h3F, '0, rd, w);
      chk(rd == patv(A + 32'h3F, 1), "R9 1-byte load zero-extended", rd, patv(A + 32'h3F, 1));
   endtask

   task automatic t_partial_write;
      logic [127:0] rd, e; int w;
      acc(1, 3'd1, A + 32'h11, {{112{1'b1}}, 16'hBEEF}, rd, w);
      chk(w == 0, "R8 store hit completes at once", w, 0);
      acc(0, 3'd2, A + 32'h10, '0, rd, w);
      e = {96'h0, pat(A + 32'h13), pat(A + 32'h12), 16'hBEEF};
      chk(rd == e, "R8 2-byte store aligned, neighbours kept", rd, e);
      acc(0, 3'd4, A + 32'h1F, '0, rd, w);
      e = patv(A + 32'h10, 16); e[15:0] = 16'hBEEF;
      chk(rd == e, "R9 16-byte load aligned down", rd, e);
   endtask

   task automatic t_replace;
      logic [127:0] rd; int w; int r0, w0;
      acc(0, 3'd2, B, '0, rd, w);
      chk(wr_count == 0 && last_rd_addr == B, "R6 empty way filled without writeback", wr_count, 0);
      acc(0, 3'd2, C, '0, rd, w);
      chk(wr_count == 1 && last_wr_addr == A, "R5 dirty victim written at its own tag", last_wr_addr, A);
      chk(last_wr_data[16*8 +: 16] == 16'hBEEF && last_wr_data[20*8 +: 8] == pat(A + 32'h14),
          "R5 writeback carries whole line", last_wr_data[16*8 +: 40], {pat(A + 32'h14), 16'h0, 16'hBEEF});
      chk(wr_seq < rd_seq && last_rd_addr == C, "R5 writeback precedes refill", {wr_seq, rd_seq}, 0);
      chk(done_cyc == ack_edge, "R10 done after writeback and fill", done_cyc, ack_edge);
      r0 = rd_count; w0 = wr_count;
      acc(0, 3'd2, B, '0, rd, w);
      chk(w == 0 && rd_count == r0, "R4 unchosen way stays resident", w, 0);
      acc(0, 3'd1, A + 32'h10, '0, rd, w);
      chk(wr_count == w0 && rd_count == r0 + 1, "R4 XOR victim is clean way, R6 no writeback",
          {wr_count, rd_count}, {w0, r0 + 1});
      chk(rd == 128'hBEEF, "R5 written-back data returns on refill", rd, 128'hBEEF);
   endtask

   task automatic t_write_allocate;
      logic [127:0] rd; int w; int r0 = rd_count;
      acc(1, 3'd0, D + 32'h5, 128'hA5, rd, w);
      chk(rd_count == r0 + 1 && last_rd_addr == D, "R8 store miss allocates", last_rd_addr, D);
      acc(0, 3'd0, D + 32'h5, '0, rd, w);
      chk(w == 0 && rd == 128'hA5, "R8 allocated store visible", rd, 128'hA5);
      acc(0, 3'd2, E, '0, rd, w);
      acc(0, 3'd2, F, '0, rd, w);
      chk(last_wr_addr == D && last_wr_data[5*8 +: 8] == 8'hA5, "R8 allocated line was dirty",
          last_wr_addr, D);
   endtask

   task automatic t_wide_access;
      logic [127:0] rd, v; int w;
      v = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3210;
      acc(1, 3'd7, F + 32'h27, v, rd, w);
      acc(0, 3'd4, F + 32'h20, '0, rd, w);
      chk(rd == v, "R9 size code above 4 acts as 16 bytes", rd, v);
      acc(0, 3'd3, F + 32'h18, '0, rd, w);
      chk(rd == patv(F + 32'h18, 8), "R8 bytes outside store unchanged", rd, patv(F + 32'h18, 8));
   endtask

   task automatic t_index_isolation;
      logic [127:0] rd; int w; int r0 = rd_count;
      acc(0, 3'd1, A + 32'h10, '0, rd, w);
      chk(w == 0 && rd_count == r0 && rd == 128'hBEEF, "R3 other set untouched", rd, 128'hBEEF);
      chk(hold_err == 0, "R11 request held stable until ack", hold_err, 0);
      chk(busy_err == 0, "R10 busy during memory transfer", busy_err, 0);
   endtask

   task automatic report;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=completion");
         report();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      t_cold_miss();
      t_hit_reads();
      t_partial_write();
      t_replace();
      t_write_allocate();
      t_wide_access();
      t_index_isolation();
      finished = 1;
      report();
   end

endmodule